// File: doc/BRIEF.md
# Bus master grant acquisition controller

This block decides when a master on a shared, multi-master parallel bus with active-low control lines may open a transaction. The local logic holds `req_i` high while it has a transaction waiting. The block then raises its active-low request to the central arbiter. It watches the arbiter's grant together with the sampled frame and initiator-ready lines of the bus.

On the first rising edge that sees its grant while the bus is idle, it starts the address phase. Frame is asserted, the address is driven and the output enables for frame and address/data all turn on after that same edge. No clock is spent enabling the drivers in advance, so a grant that lasts a single clock is enough. A grant that arrives while the bus is busy is not used, and the request stays up for a later grant.

After the address phase the block holds frame through the data phase until the data path raises `last_i`. It then releases frame and spends one turnaround clock with its frame driver off. After that it may request again. Data transfer, target decoding and parity belong to other blocks.

Top module: `bus_grant_ctrl`

## Requirements
- R1: While `rst_ni` is low, and on the first edges after it rises with no request, `req_no`=1, `frame_no`=1, `frame_oe_o`=0, `ad_oe_o`=0 and `addr_phase_o`=0.
- R2: With no transaction active, an edge that samples `req_i`=1 makes `req_no`=0 after that edge, and the block waits for a grant.
- R3: While requesting, an edge that samples `gnt_ni`=0, `frame_ni`=1 and `irdy_ni`=1 with `req_i`=1 sets `frame_no`=0, `frame_oe_o`=1, `ad_oe_o`=1 and `addr_phase_o`=1 together after that same edge. Neither enable is on in any earlier clock. `frame_no` falls only after such an edge.
- R4: A grant that is low for exactly one clock, on an idle bus, is enough to start the transaction.
- R5: A grant sampled while the bus is busy (`frame_ni`=0 or `irdy_ni`=0) starts nothing. `req_no` stays 0 and frame stays released.
- R6: The address phase lasts one clock. After it, `ad_oe_o`=0 and `addr_phase_o`=0 while `frame_no`=0 and `frame_oe_o`=1 hold until `last_i` is sampled high.
- R7: In the data phase, an edge that samples `last_i`=1 sets `frame_no`=1 and `frame_oe_o`=0 after that edge.
- R8: The turnaround lasts exactly one clock, with `req_no`=1 and all enables off. After it, the block requests again if `req_i`=1 and otherwise stays quiet.
- R9: On the edge that ends the address phase, `req_no` becomes the inverse of the sampled `req_i`. A queued transaction keeps the request asserted through the data phase.
- R10: If `req_i` falls while the block is requesting, `req_no` returns to 1 after the next edge and no transaction starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock, rising edge active |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Local logic has a transaction waiting |
| last_i | input | 1 | Data path: final data phase completes at this edge |
| gnt_ni | input | 1 | Active-low grant from the arbiter |
| frame_ni | input | 1 | Sampled bus frame line, active low |
| irdy_ni | input | 1 | Sampled bus initiator-ready line, active low |
| req_no | output | 1 | Active-low request to the arbiter |
| frame_no | output | 1 | Frame value to drive, active low |
| frame_oe_o | output | 1 | Output enable of the frame driver |
| ad_oe_o | output | 1 | Output enable of the address/data drivers |
| addr_phase_o | output | 1 | Selects the address onto address/data in this clock |

## Verification
Every output is registered, so each result is due right after the rising edge that samples its cause, with no further delay: start, release, turnaround and request changes all appear one edge after the inputs that trigger them. The bench changes inputs 5 ns after a rising edge. It copies the inputs into its reference model on the next rising edge and compares all five outputs at the falling edge that follows, so each comparison lands in the one clock where the result must first appear. The one-clock grant and the missed grant are also checked directly, in the clock right after the grant edge.

// File: rtl/bgc_pkg.sv
package bgc_pkg;
  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_REQ  = 3'd1,
    ST_ADDR = 3'd2,
    ST_BUSY = 3'd3,
    ST_TURN = 3'd4
  } bgc_state_e;
endpackage

// File: rtl/bgc_fsm.sv
module bgc_fsm
  import bgc_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       req_i,
  input  logic       last_i,
  input  logic       gnt_ni,
  input  logic       frame_ni,
  input  logic       irdy_ni,
  output bgc_state_e state_q_o,
  output bgc_state_e state_d_o
);
  bgc_state_e state_q, state_d;
  logic       bus_idle, win;

  assign bus_idle = frame_ni & irdy_ni;
  assign win      = ~gnt_ni & bus_idle;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (req_i) state_d = ST_REQ;
      ST_REQ: begin
        if (!req_i)   state_d = ST_IDLE;
        else if (win) state_d = ST_ADDR;  // start on the first grant+idle edge
      end
      ST_ADDR: state_d = ST_BUSY;
      ST_BUSY: if (last_i) state_d = ST_TURN;
      ST_TURN: state_d = req_i ? ST_REQ : ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  assign state_q_o = state_q;
  assign state_d_o = state_d;

  // R3
  start_on_win_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_ADDR) |-> $past(!gnt_ni && frame_ni && irdy_ni && req_i));

  // R5
  busy_grant_ignored_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_REQ && req_i && !gnt_ni && !(frame_ni && irdy_ni)) |=> (state_q == ST_REQ));

  // R8
  turn_one_clock_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_TURN) |=> (state_q == ST_REQ || state_q == ST_IDLE));
endmodule

// File: rtl/bgc_outreg.sv
module bgc_outreg
  import bgc_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       req_i,
  input  bgc_state_e state_d_i,
  output logic       req_no,
  output logic       frame_no,
  output logic       frame_oe_o,
  output logic       ad_oe_o,
  output logic       addr_phase_o
);
  logic own_d, addr_d, ask_d;

  assign own_d  = (state_d_i == ST_ADDR) || (state_d_i == ST_BUSY);
  assign addr_d = (state_d_i == ST_ADDR);
  // request held while work waits, except in turnaround
  assign ask_d  = req_i && (state_d_i != ST_TURN) && (state_d_i != ST_IDLE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_no       <= 1'b1;
      frame_no     <= 1'b1;
      frame_oe_o   <= 1'b0;
      ad_oe_o      <= 1'b0;
      addr_phase_o <= 1'b0;
    end else begin
      req_no       <= ~ask_d;
      frame_no     <= ~own_d;
      frame_oe_o   <= own_d;
      ad_oe_o      <= addr_d;
      addr_phase_o <= addr_d;
    end
  end

  // R3
  oe_with_frame_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(frame_oe_o) |-> (!frame_no && ad_oe_o && addr_phase_o));

  // R6
  addr_one_clock_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    addr_phase_o |=> (!addr_phase_o && !ad_oe_o && frame_oe_o && !frame_no));

  // R8
  no_req_in_turn_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(frame_oe_o) |-> req_no);
endmodule

// File: rtl/bus_grant_ctrl.sv
module bus_grant_ctrl
  import bgc_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_i,
  input  logic last_i,
  input  logic gnt_ni,
  input  logic frame_ni,
  input  logic irdy_ni,
  output logic req_no,
  output logic frame_no,
  output logic frame_oe_o,
  output logic ad_oe_o,
  output logic addr_phase_o
);
  bgc_state_e state_q, state_d;

  bgc_fsm u_fsm (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .req_i    (req_i),
    .last_i   (last_i),
    .gnt_ni   (gnt_ni),
    .frame_ni (frame_ni),
    .irdy_ni  (irdy_ni),
    .state_q_o(state_q),
    .state_d_o(state_d)
  );

  bgc_outreg u_out (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .req_i       (req_i),
    .state_d_i   (state_d),
    .req_no      (req_no),
    .frame_no    (frame_no),
    .frame_oe_o  (frame_oe_o),
    .ad_oe_o     (ad_oe_o),
    .addr_phase_o(addr_phase_o)
  );

  // R7
  release_on_last_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_BUSY && last_i) |=> (frame_no && !frame_oe_o));

  // R1
  quiet_when_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IDLE) |-> (!frame_oe_o && !ad_oe_o && frame_no));
endmodule

// File: tb/bus_grant_ctrl_tb.sv
`timescale 1ns/1ps
module bus_grant_ctrl_tb;
  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic req_i = 1'b0, last_i = 1'b0, gnt_ni = 1'b1;
  logic frame_ni, irdy_ni;
  logic req_no, frame_no, frame_oe_o, ad_oe_o, addr_phase_o;

  int oth_cnt = 0;
  int tests = 0, fails = 0;
  bit done = 1'b0;

  always #10 clk_i = ~clk_i;

  // composite bus: own drivers or another master
  assign frame_ni = frame_oe_o ? frame_no : !(oth_cnt > 1);
  assign irdy_ni  = (frame_oe_o && !addr_phase_o) ? 1'b0 : !(oth_cnt >= 1);

  bus_grant_ctrl u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .req_i(req_i), .last_i(last_i),
    .gnt_ni(gnt_ni), .frame_ni(frame_ni), .irdy_ni(irdy_ni),
    .req_no(req_no), .frame_no(frame_no), .frame_oe_o(frame_oe_o),
    .ad_oe_o(ad_oe_o), .addr_phase_o(addr_phase_o)
  );

  // reference model: 0 idle, 1 req, 2 addr, 3 busy, 4 turn
  int m_st = 0;
  string m_tag = "R1";
  bit win_seen = 1'b0;
  bit prev_frame = 1'b1;

  function automatic int next_st(int s, bit rq, bit g, bit idle, bit lst);
    case (s)
      0: return rq ? 1 : 0;
      1: return !rq ? 0 : ((g && idle) ? 2 : 1);
      2: return 3;
      3: return lst ? 4 : 3;
      default: return rq ? 1 : 0;
    endcase
  endfunction

  function automatic string tag_of(int s, bit rq, bit g, bit idle, bit lst);
    case (s)
      0: return rq ? "R2" : "R1";
      1: if (!rq) return "R10";
         else if (g && idle) return "R3";
         else if (g) return "R5";
         else return "R2";
      2: return "R9";
      3: return lst ? "R7" : "R6";
      default: return "R8";
    endcase
  endfunction

  always @(posedge clk_i) begin
    if (!rst_ni) begin
      m_st = 0; m_tag = "R1"; win_seen = 1'b0;
    end else begin
      m_tag = tag_of(m_st, req_i, !gnt_ni, frame_ni && irdy_ni, last_i);
      win_seen = !gnt_ni && frame_ni && irdy_ni && req_i;
      m_st = next_st(m_st, req_i, !gnt_ni, frame_ni && irdy_ni, last_i);
      m_rq = req_i;
    end
  end
  bit m_rq = 1'b0;

  task automatic chk(string tag, string what, logic act, logic exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%b expected=%b t=%0t", tag, what, act, exp, $time);
    end
  endtask

  always @(negedge clk_i) begin
    if (!done) begin
      bit own, ad, ask;
      own = (m_st == 2 || m_st == 3);
      ad  = (m_st == 2);
      ask = m_rq && m_st != 4 && m_st != 0 && rst_ni;
      chk(m_tag, "req_no",       req_no,       !ask);
      chk(m_tag, "frame_no",     frame_no,     !own);
      chk(m_tag, "frame_oe_o",   frame_oe_o,   own);
      chk(m_tag, "ad_oe_o",      ad_oe_o,      ad);
      chk(m_tag, "addr_phase_o", addr_phase_o, ad);
      if (prev_frame && !frame_no) chk("R3", "frame fell after grant+idle", win_seen, 1'b1);
      prev_frame = frame_no;
    end
  end

  task automatic tick();
    @(posedge clk_i); #5;
    if (oth_cnt > 0) oth_cnt--;
  endtask

  initial begin : watchdog
    repeat (50000) @(posedge clk_i);
    if (!done) begin
      done = 1'b1;
      fails++; tests++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin : stim
    int pend = 0, gcnt = 0;
    process_seed();
    repeat (3) tick();
    chk("R1", "reset req_no", req_no, 1'b1);
    chk("R1", "reset frame_oe_o", frame_oe_o, 1'b0);
    rst_ni = 1'b1;
    tick(); tick();
    // directed: one-clock grant on idle bus
    req_i = 1'b1; tick(); tick();
    gnt_ni = 1'b0; tick();
    gnt_ni = 1'b1;
    chk("R4", "one-clock grant frame_no", frame_no, 1'b0);
    chk("R4", "one-clock grant ad_oe_o", ad_oe_o, 1'b1);
    req_i = 1'b0; tick(); tick();
    last_i = 1'b1; tick(); last_i = 1'b0;
    tick(); tick();
    // directed: one-clock grant while bus busy
    req_i = 1'b1; tick(); tick();
    oth_cnt = 4; gnt_ni = 1'b0; tick();
    gnt_ni = 1'b1;
    chk("R5", "missed grant req_no", req_no, 1'b0);
    chk("R5", "missed grant frame_oe_o", frame_oe_o, 1'b0);
    repeat (5) tick();
    chk("R5", "still requesting", req_no, 1'b0);
    gnt_ni = 1'b0; tick(); gnt_ni = 1'b1;
    chk("R4", "later grant starts", addr_phase_o, 1'b1);
    // queued transaction behind the current one
    tick();
    last_i = 1'b1; tick(); last_i = 1'b0;
    chk("R8", "turnaround req_no", req_no, 1'b1);
    tick();
    chk("R8", "requests after turnaround", req_no, 1'b0);
    req_i = 1'b0; tick(); tick();
    // random phase
    pend = 0;
    for (int i = 0; i < 4000; i++) begin
      tick();
      if (addr_phase_o && pend > 0) pend--;
      if ($urandom_range(0, 9) == 0) pend++;
      req_i = (pend > 0);
      if (gcnt == 0 && ($urandom_range(0, 3) == 0) && (!req_no || $urandom_range(0, 7) == 0))
        gcnt = $urandom_range(1, 3);
      gnt_ni = !(gcnt > 0);
      if (gcnt > 0) gcnt--;
      if (oth_cnt == 0 && !frame_oe_o && frame_ni && irdy_ni && $urandom_range(0, 7) == 0)
        oth_cnt = $urandom_range(2, 5);
      last_i = frame_oe_o && !addr_phase_o && ($urandom_range(0, 2) == 0);
    end
    tick(); tick();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  task automatic process_seed();
    int unused;
    unused = $urandom(32'h5eed_1234);
  endtask
endmodule